// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the serial clock of an I2C master. The transaction engine enables it and pulses a start request. From then on the block alternates a driven-low phase and a released-high phase on SCL, and emits a single-cycle strobe at each edge so that the bit engine knows when to change SDA and when SCL has gone high. Two programmed words set the timing, and both are computed by software from the functional clock frequency. The first word holds a 16-bit baud count. The second holds a data setup count. A 2-bit speed select chooses the phase split. The clocking runs continuously while the enable stays high.

A bit period is a whole number of baud units, and each unit is one baud count of functional-clock cycles. Standard timing uses one unit low and one unit high. Fast and fast-plus timing use two units low and one unit high. The block watches the sampled SCL line. If SCL is still low while the block has released it, a slave is stretching the clock. In that case the high-phase count freezes. When SCL is seen high again, a setup delay runs first and then the high-phase count resumes. The FSM states are IDLE, LOW, HIGH, STRETCH and SETUP. The transitions are as follows:
- IDLE to LOW on an accepted start.
- LOW to HIGH when the last low unit ends.
- HIGH to LOW when the high unit ends.
- HIGH to STRETCH when SCL is sampled low.
- STRETCH to SETUP when SCL is sampled high.
- SETUP to STRETCH when SCL drops again.
- SETUP to HIGH when the setup delay expires.
- Any state to IDLE when the enable is low.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset the block is inactive: `active`=0, `scl_drive_low`=0, and all three tick outputs are 0.
- R2: A `start` sampled high while `enable`=1 and the block is idle enters the low phase on that clock edge. In the next cycle `scl_drive_low`=1, `active`=1 and `fall_tick`=1, where `fall_tick` marks the first cycle of every low phase.
- R3: With `speed_mode`=0 (standard), the low phase lasts B cycles and the full period lasts 2B cycles, where B is the baud count.
- R4: With `speed_mode`=1 (fast) or 2 (fast-plus), the low phase lasts 2B cycles and the full period lasts 3B cycles, with exactly one `fall_tick` per period.
- R5: `speed_mode`=3 falls back to standard timing (low B, period 2B).
- R6: B is `baud_word[15:0]`, and `baud_word[31:16]` has no effect. B=0 is treated as 1.
- R7: While SCL is released but `scl_in` is low, the high-phase count is frozen and no `fall_tick` occurs.
- R8: When a stretched SCL is seen high, a delay of S+1 cycles runs, where S is `setup_word[31:16]` and `setup_word[15:0]` has no effect. Then `setup_done_tick` pulses in the first cycle of the resumed high count, and the full B high cycles follow. If the release is observed after N≥1 frozen cycles, the next `fall_tick` comes N+S+2+B cycles after `rise_tick`.
- R9: S=0 still produces a one-cycle setup wait.
- R10: With `enable`=0 the block returns to idle on the next edge, with SCL released and no ticks. A `start` while `enable`=0 is ignored.
- R11: Baud count, speed select and setup count are captured at the accepted start. A `start` pulse or a change to the programmed words while running does not alter the timing already in progress.
- R12: At most one tick pulses per cycle. `rise_tick` pulses only in the first released cycle after a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable from the transaction engine |
| start | input | 1 | Start request, accepted only when idle and enabled |
| baud_word | input | 32 | Baud count in bits 15:0; bits 31:16 ignored |
| setup_word | input | 32 | Setup count in bits 31:16; bits 15:0 ignored |
| speed_mode | input | 2 | 0 standard, 1 fast, 2 fast-plus, 3 treated as standard |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_tick | output | 1 | First cycle of a low phase |
| rise_tick | output | 1 | First released cycle after a low phase |
| setup_done_tick | output | 1 | First cycle of the resumed high count after a stretch |
| active | output | 1 | Block is generating SCL |

## Verification
The assertions assume that `scl_in` is low whenever `scl_drive_low` is high, as on a real wired-AND bus. They also assume that the line is already high in the cycle after release unless a slave holds it. The bench builds `scl_in` combinationally as the inverse of the block's own drive, ANDed with a stretch-hold control. This keeps the stimulus inside those assumptions. Stretch holds are raised during a low phase and released at chosen cycles after `rise_tick`, so that the frozen count and the setup window can be measured exactly.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    localparam int CNT_W  = 16;
    localparam int UNIT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_STRETCH,
        ST_SETUP
    } scl_state_e;

    typedef enum logic [1:0] {
        SPD_STD      = 2'd0,
        SPD_FAST     = 2'd1,
        SPD_FASTPLUS = 2'd2,
        SPD_HIGH     = 2'd3
    } spd_e;

    // Baud units spent low per period; fast modes stretch the low phase.
    function automatic logic [UNIT_W-1:0] low_units(input logic [1:0] mode);
        logic [UNIT_W-1:0] u;
        case (mode)
            SPD_FAST, SPD_FASTPLUS: u = UNIT_W'(2);
            default:                u = UNIT_W'(1);
        endcase
        return u;
    endfunction

endpackage

// File: rtl/scl_unit_timer.sv
module scl_unit_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             unit_done
);

    logic [CNT_W-1:0] cnt_q;

    // limit is always at least one, so limit-1 does not wrap
    assign unit_done = run && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            if (unit_done) cnt_q <= '0;
            else           cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/scl_setup_delay.sv
module scl_setup_delay #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    assign expired = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BAUD_LSB  = 0,
    parameter int SETUP_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [WORD_W-1:0] baud_word,
    input  logic [WORD_W-1:0] setup_word,
    input  logic [1:0]        speed_mode,
    input  logic              scl_in,
    output logic              scl_drive_low,
    output logic              fall_tick,
    output logic              rise_tick,
    output logic              setup_done_tick,
    output logic              active
);

    localparam int BAUD_MSB  = BAUD_LSB + CNT_W - 1;
    localparam int SETUP_MSB = SETUP_LSB + CNT_W - 1;

    scl_state_e        state_q, state_nx;
    logic [CNT_W-1:0]  baud_q, setup_q;
    logic [UNIT_W-1:0] low_units_q, units_left_q;
    logic              fall_q, rise_q, resume_q;

    logic [CNT_W-1:0]  baud_field, baud_eff, setup_field;
    logic              start_ok;
    logic              unit_done, setup_expired;
    logic              tmr_clear, tmr_run;
    logic              dly_load, dly_run;
    logic              unused_bits;

    assign baud_field  = baud_word[BAUD_MSB:BAUD_LSB];
    assign setup_field = setup_word[SETUP_MSB:SETUP_LSB];
    assign baud_eff    = (baud_field == '0) ? CNT_W'(1) : baud_field;
    assign unused_bits = ^{baud_word[WORD_W-1:BAUD_MSB+1], setup_word[SETUP_LSB-1:0]};

    assign start_ok = enable && start && (state_q == ST_IDLE);

    // Unit timer: one baud count per unit, frozen while SCL is held low
    assign tmr_clear = start_ok || !enable;
    assign tmr_run   = (state_q == ST_LOW) || ((state_q == ST_HIGH) && scl_in);

    scl_unit_timer #(.CNT_W(CNT_W)) u_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tmr_clear),
        .run       (tmr_run),
        .limit     (baud_q),
        .unit_done (unit_done)
    );

    // Setup delay: loaded when the stretched line is first seen high
    assign dly_load = (state_q == ST_STRETCH) && scl_in;
    assign dly_run  = (state_q == ST_SETUP) && scl_in;

    scl_setup_delay #(.CNT_W(CNT_W)) u_setup (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (setup_q),
        .run      (dly_run),
        .expired  (setup_expired)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) state_nx = ST_LOW;
            end
            ST_LOW: begin
                if (unit_done && (units_left_q == UNIT_W'(1))) state_nx = ST_HIGH;
            end
            ST_HIGH: begin
                if (!scl_in)        state_nx = ST_STRETCH;
                else if (unit_done) state_nx = ST_LOW;
            end
            ST_STRETCH: begin
                if (scl_in) state_nx = ST_SETUP;
            end
            ST_SETUP: begin
                if (!scl_in)            state_nx = ST_STRETCH;
                else if (setup_expired) state_nx = ST_HIGH;
            end
            default: state_nx = ST_IDLE;
        endcase
        if (!enable) state_nx = ST_IDLE;
    end

    // State register, captured configuration and edge strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            baud_q       <= CNT_W'(1);
            setup_q      <= '0;
            low_units_q  <= UNIT_W'(1);
            units_left_q <= '0;
            fall_q       <= 1'b0;
            rise_q       <= 1'b0;
            resume_q     <= 1'b0;
        end else begin
            state_q  <= state_nx;
            fall_q   <= (state_nx == ST_LOW) && (state_q != ST_LOW);
            rise_q   <= (state_q == ST_LOW) && (state_nx == ST_HIGH);
            resume_q <= (state_q == ST_SETUP) && (state_nx == ST_HIGH);
            if (start_ok) begin
                baud_q       <= baud_eff;
                setup_q      <= setup_field;
                low_units_q  <= low_units(speed_mode);
                units_left_q <= low_units(speed_mode);
            end else if ((state_q == ST_HIGH) && (state_nx == ST_LOW)) begin
                units_left_q <= low_units_q;
            end else if ((state_q == ST_LOW) && unit_done) begin
                units_left_q <= units_left_q - UNIT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        scl_drive_low   = (state_q == ST_LOW);
        active          = (state_q != ST_IDLE);
        fall_tick       = fall_q;
        rise_tick       = rise_q;
        setup_done_tick = resume_q;
    end

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_in,
    input logic scl_drive_low,
    input logic fall_tick,
    input logic rise_tick,
    input logic setup_done_tick,
    input logic active
);

    // R12
    ticks_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_tick, rise_tick, setup_done_tick}));

    // R10
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!active && !scl_drive_low));

    // R2
    start_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (fall_tick && scl_drive_low));

    // R7
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !scl_drive_low && !scl_in) |=> !fall_tick);

    // R12
    rise_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |-> (!scl_drive_low && $past(scl_drive_low)));

    // R8
    setup_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done_tick |-> (active && !scl_drive_low && $past(scl_in)));

endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable          (enable),
    .scl_in          (scl_in),
    .scl_drive_low   (scl_drive_low),
    .fall_tick       (fall_tick),
    .rise_tick       (rise_tick),
    .setup_done_tick (setup_done_tick),
    .active          (active)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        start = 1'b0;
    logic [31:0] baud_word = 32'd1;
    logic [31:0] setup_word = 32'd0;
    logic [1:0]  speed_mode = 2'd0;
    logic        hold = 1'b0;
    logic        scl_in;
    logic        scl_drive_low, fall_tick, rise_tick, setup_done_tick, active;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // wired-AND line: low when driven or when a slave holds it
    assign scl_in = ~scl_drive_low & ~hold;

    scl_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .baud_word(baud_word), .setup_word(setup_word), .speed_mode(speed_mode),
        .scl_in(scl_in), .scl_drive_low(scl_drive_low), .fall_tick(fall_tick),
        .rise_tick(rise_tick), .setup_done_tick(setup_done_tick), .active(active)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // which: 0 fall, 1 rise, 2 setup_done
    task automatic wait_tick(input int which, output int t);
        t = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ((which == 0 && fall_tick) || (which == 1 && rise_tick) ||
                (which == 2 && setup_done_tick)) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic stop_block();
        @(negedge clk);
        enable = 1'b0;
        hold = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // returns cycle of the first fall_tick; checks R2
    task automatic begin_run(input logic [31:0] bw, input logic [31:0] sw,
                             input logic [1:0] md, output int t0);
        baud_word = bw; setup_word = sw; speed_mode = md;
        enable = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0 = cyc;
        chk("R2 fall_tick after start", int'(fall_tick), 1);
        chk("R2 drive low after start", int'(scl_drive_low && active), 1);
    endtask

    task automatic measure(input string tag, input int t0, input int exp_low, input int exp_per);
        int t1, t2;
        wait_tick(1, t1);
        wait_tick(0, t2);
        chk({tag, " low length"}, t1 - t0, exp_low);
        chk({tag, " period"}, t2 - t0, exp_per);
    endtask

    task automatic test_reset();
        chk("R1 idle after reset", int'({active, scl_drive_low, fall_tick, rise_tick, setup_done_tick}), 0);
    endtask

    task automatic test_standard();
        int t0;
        begin_run(32'd5, 32'd0, 2'd0, t0);
        measure("R3 std B=5", t0, 5, 10);
        stop_block();
        begin_run(32'd2, 32'd0, 2'd0, t0);
        measure("R3 std B=2", t0, 2, 4);
        stop_block();
    endtask

    task automatic test_fast();
        int t0, falls;
        begin_run(32'd4, 32'd0, 2'd1, t0);
        measure("R4 fast B=4", t0, 8, 12);
        falls = 0;
        for (int i = 0; i < 36; i++) begin
            @(negedge clk);
            if (fall_tick) falls++;
        end
        chk("R4 one fall per period", falls, 3);
        stop_block();
        begin_run(32'd3, 32'd0, 2'd2, t0);
        measure("R4 fast-plus B=3", t0, 6, 9);
        stop_block();
    endtask

    task automatic test_fallback();
        int t0;
        begin_run(32'd4, 32'd0, 2'd3, t0);
        measure("R5 mode3 fallback", t0, 4, 8);
        stop_block();
    endtask

    task automatic test_baud_field();
        int t0;
        begin_run(32'hABCD_0003, 32'd0, 2'd0, t0);
        measure("R6 upper baud bits ignored", t0, 3, 6);
        stop_block();
        begin_run(32'hFFFF_0000, 32'd0, 2'd0, t0);
        measure("R6 baud zero as one", t0, 1, 2);
        stop_block();
    endtask

    // hold SCL low through the rise, release after n frozen cycles
    task automatic stretch_run(input string tag, input int b, input int s, input int n);
        int t0, tr, td, tf;
        begin_run(b, {16'(s), 16'hFFFF}, 2'd0, t0);
        hold = 1'b1;
        wait_tick(1, tr);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({tag, " frozen no fall"}, int'(fall_tick || scl_drive_low), 0);
        end
        hold = 1'b0;
        wait_tick(2, td);
        chk({tag, " setup_done offset"}, td - tr, n + 2 + s);
        wait_tick(0, tf);
        chk({tag, " fall after stretch"}, tf - tr, n + 2 + s + b);
        stop_block();
    endtask

    task automatic test_disable();
        int t0, bad;
        begin_run(32'd5, 32'd0, 2'd0, t0);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R10 idle after disable", int'(active || scl_drive_low), 0);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (active || scl_drive_low || fall_tick || rise_tick || setup_done_tick) bad++;
        end
        chk("R10 quiet while disabled", bad, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R10 start ignored when disabled", int'(active || fall_tick), 0);
    endtask

    task automatic test_running_changes();
        int t0;
        begin_run(32'd4, 32'd0, 2'd0, t0);
        @(negedge clk);
        start = 1'b1;
        baud_word = 32'd9;
        speed_mode = 2'd1;
        @(negedge clk);
        start = 1'b0;
        measure("R11 config held while running", t0, 4, 8);
        stop_block();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_standard();
        test_fast();
        test_fallback();
        test_baud_field();
        stretch_run("R7 R8 stretch S=3", 6, 3, 10);
        stretch_run("R9 setup zero", 5, 0, 4);
        test_disable();
        test_running_changes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        errors++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule